// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

This block is a 32-pin general-purpose I/O port behind a small word-wide register bus. Software writes an output data word and a per-pin direction word. The data word drives the pads wherever the direction bit enables the driver. Software reads back the pad levels after a two-flop synchroniser. It can also have any pin raise an interrupt on a level or on an edge of its input.

Each pin has a two-bit trigger code. The codes for pins 0 to 15 sit in one configuration register and those for pins 16 to 31 in a second one. A separate per-pin override bit makes a pin fire on both edges. Detected events latch into a write-one-to-clear status word. A mask word then gates that status onto two interrupt lines, one for the lower sixteen pins and one for the upper sixteen.

Reads take one cycle: `bus_rdata` shows, one clock after the address is presented, the register contents at that clock edge.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers are word-addressed by byte offset, decoded from address bits [4:2]: output data 0x00, direction 0x04, pad status 0x08 (read only), trigger codes for pins 0-15 at 0x0C, trigger codes for pins 16-31 at 0x10, mask 0x14, status 0x18, both-edge override 0x1C. Writable registers read back their last written value. Reading 0x00 returns the written data and not the pads. A write whose address bits [1:0] are nonzero is discarded.
- R2: `pad_oe` equals the direction register (1 = driven) and `pad_out` equals the output data register, both updated on the clock edge that performs the write.
- R3: The pad status register returns `pad_in` after a two-flop synchroniser.
- R4: A pin's trigger code occupies bits [2k+1:2k] with k = pin mod 16, in the low-pin register for pins 0-15 and in the high-pin register for pins 16-31. The code values are 00 = input low, 01 = input high, 10 = rising edge, 11 = falling edge.
- R5: For a level code, the status bit is set on every cycle the level holds, so a clear has no lasting effect while the level persists.
- R6: For an edge code, the status bit is set once per matching edge of the synchronised input and stays set until cleared. An edge of the other polarity has no effect.
- R7: When a pin's override bit is 1, the pin sets status on both rising and falling edges and its two-bit code is ignored.
- R8: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq_lo` is the OR over pins 0-15 of (status AND mask), and `irq_hi` is the same over pins 16-31. Both are registered one cycle after status and mask. A mask bit of 1 enables the pin.
- R11: Reset (synchronous, active high) sets every register, `bus_rdata`, `pad_out`, `pad_oe` and both interrupt lines to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin (1 = driven) |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
The bench targets the defaults right after reset. All codes are zero, so every low pad counts as a pending low-level event. A design that decoded 00 as an edge would show an empty status word here. The bench clears a level-triggered bit while its level persists, where a design that let the clear win would drop the interrupt. It sends an edge to a pin whose code selects the other polarity, and toggles a pin with the override bit set whose code says rising only. A field-position or override bug would show up there as a missing or spurious status bit. It writes to the status word with mixed ones and zeros and with a misaligned address, and places a high-half pin on each line to catch swapped or merged interrupt outputs.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Two-bit per-pin trigger code
  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'b00,
    TRIG_LVL_HIGH = 2'b01,
    TRIG_RISE     = 2'b10,
    TRIG_FALL     = 2'b11
  } trig_e;

  // Word indices (byte offset / 4)
  localparam int unsigned WI_DATA = 0;
  localparam int unsigned WI_DIR  = 1;
  localparam int unsigned WI_PAD  = 2;
  localparam int unsigned WI_CFGL = 3;
  localparam int unsigned WI_CFGH = 4;
  localparam int unsigned WI_MASK = 5;
  localparam int unsigned WI_STAT = 6;
  localparam int unsigned WI_BOTH = 7;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dprev
);

  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign dout  = chain[STAGES-1];
  assign dprev = prev_q;

endmodule

// File: rtl/gpio_pin_trigger.sv
module gpio_pin_trigger
  import gpio_irq_pkg::*;
(
  input  logic [1:0] trig_cfg,
  input  logic       both_en,
  input  logic       cur,
  input  logic       prv,
  output logic       hit
);

  trig_e mode;
  assign mode = trig_e'(trig_cfg);

  always_comb begin
    if (both_en) begin
      hit = cur ^ prv;
    end else begin
      unique case (mode)
        TRIG_LVL_LOW:  hit = ~cur;
        TRIG_LVL_HIGH: hit = cur;
        TRIG_RISE:     hit = cur & ~prv;
        TRIG_FALL:     hit = ~cur & prv;
        default:       hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  localparam int HALF   = DATA_W / 2;
  localparam int WIDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] data_q, dir_q, cfgl_q, cfgh_q, mask_q, stat_q, both_q;
  logic [DATA_W-1:0] pad_sync, pad_prev, evt_vec, clr_vec;
  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic              wr_data, wr_dir, wr_cfgl, wr_cfgh, wr_mask, wr_stat, wr_both;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_data = bus_we && aligned && (widx == WIDX_W'(WI_DATA));
  assign wr_dir  = bus_we && aligned && (widx == WIDX_W'(WI_DIR));
  assign wr_cfgl = bus_we && aligned && (widx == WIDX_W'(WI_CFGL));
  assign wr_cfgh = bus_we && aligned && (widx == WIDX_W'(WI_CFGH));
  assign wr_mask = bus_we && aligned && (widx == WIDX_W'(WI_MASK));
  assign wr_stat = bus_we && aligned && (widx == WIDX_W'(WI_STAT));
  assign wr_both = bus_we && aligned && (widx == WIDX_W'(WI_BOTH));

  gpio_pad_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (pad_in),
    .dout  (pad_sync),
    .dprev (pad_prev)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    localparam int FPOS = 2 * (i % HALF);
    logic [1:0] fld;
    if (i < HALF) begin : g_lo
      assign fld = cfgl_q[FPOS +: 2];
    end else begin : g_hi
      assign fld = cfgh_q[FPOS +: 2];
    end
    gpio_pin_trigger u_trig (
      .trig_cfg (fld),
      .both_en  (both_q[i]),
      .cur      (pad_sync[i]),
      .prv      (pad_prev[i]),
      .hit      (evt_vec[i])
    );
  end

  assign clr_vec = wr_stat ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; dir_q <= '0; cfgl_q <= '0; cfgh_q <= '0;
      mask_q <= '0; stat_q <= '0; both_q <= '0;
      irq_lo <= 1'b0; irq_hi <= 1'b0;
    end else begin
      if (wr_data) data_q <= bus_wdata;
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_cfgl) cfgl_q <= bus_wdata;
      if (wr_cfgh) cfgh_q <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_both) both_q <= bus_wdata;
      stat_q <= (stat_q & ~clr_vec) | evt_vec;
      irq_lo <= |(stat_q[HALF-1:0] & mask_q[HALF-1:0]);
      irq_hi <= |(stat_q[DATA_W-1:HALF] & mask_q[DATA_W-1:HALF]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (widx)
        WIDX_W'(WI_DATA): bus_rdata <= data_q;
        WIDX_W'(WI_DIR):  bus_rdata <= dir_q;
        WIDX_W'(WI_PAD):  bus_rdata <= pad_sync;
        WIDX_W'(WI_CFGL): bus_rdata <= cfgl_q;
        WIDX_W'(WI_CFGH): bus_rdata <= cfgh_q;
        WIDX_W'(WI_MASK): bus_rdata <= mask_q;
        WIDX_W'(WI_STAT): bus_rdata <= stat_q;
        WIDX_W'(WI_BOTH): bus_rdata <= both_q;
        default:          bus_rdata <= '0;
      endcase
    end
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  // R2: a direction write reaches the enables on the next edge
  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> (pad_oe == $past(bus_wdata)));

  // R8: with no event pending, every bit written as one is cleared
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && evt_vec == '0) |=> ((stat_q & $past(bus_wdata)) == '0));

  // R9: detected events always land in status, even under a clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|evt_vec) |=> ((stat_q & $past(evt_vec)) == $past(evt_vec)));

  // R10: an interrupt line needs an enabled pin in its half
  assert_irq_lo_masked_R10: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(|mask_q[HALF-1:0]));

  assert_irq_hi_masked_R10: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(|mask_q[DATA_W-1:HALF]));

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

  localparam logic [2:0] OP_W = 3'd0; // write addr,data
  localparam logic [2:0] OP_R = 3'd1; // read addr, compare exp
  localparam logic [2:0] OP_P = 3'd2; // set pads = data, wait 4 cycles
  localparam logic [2:0] OP_I = 3'd3; // after one cycle, {irq_hi,irq_lo} == exp[1:0]
  localparam logic [2:0] OP_O = 3'd4; // pad_out & pad_oe == exp

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 57;
  localparam vec_t VECS [NVEC] = '{
    '{OP_W, 5'h00, 32'hA5A50F0F, 32'h0, 4'd1},        // R1
    '{OP_W, 5'h04, 32'hFFFF0000, 32'h0, 4'd2},        // R2
    '{OP_R, 5'h00, 32'h0, 32'hA5A50F0F, 4'd1},        // R1
    '{OP_R, 5'h04, 32'h0, 32'hFFFF0000, 4'd1},        // R1
    '{OP_O, 5'h00, 32'h0, 32'hA5A50000, 4'd2},        // R2
    '{OP_W, 5'h0C, 32'hAAAAAAAA, 32'h0, 4'd4},        // R4 all rising
    '{OP_W, 5'h10, 32'hAAAAAAAA, 32'h0, 4'd4},
    '{OP_W, 5'h18, 32'hFFFFFFFF, 32'h0, 4'd8},        // R8 clear all
    '{OP_R, 5'h18, 32'h0, 32'h00000000, 4'd8},
    '{OP_P, 5'h00, 32'h00000011, 32'h0, 4'd6},        // R6 rise on pins 0,4
    '{OP_R, 5'h18, 32'h0, 32'h00000011, 4'd6},
    '{OP_I, 5'h00, 32'h0, 32'h0, 4'd10},              // R10 masked off
    '{OP_W, 5'h14, 32'h00000001, 32'h0, 4'd10},
    '{OP_I, 5'h00, 32'h0, 32'h1, 4'd10},              // R10 irq_lo
    '{OP_W, 5'h18, 32'h00000010, 32'h0, 4'd8},        // R8 clear pin4 only
    '{OP_R, 5'h18, 32'h0, 32'h00000001, 4'd8},
    '{OP_R, 5'h08, 32'h0, 32'h00000011, 4'd3},        // R3
    '{OP_R, 5'h00, 32'h0, 32'hA5A50F0F, 4'd1},        // R1 data, not pads
    '{OP_P, 5'h00, 32'h00000001, 32'h0, 4'd6},        // R6 fall on rising pin
    '{OP_R, 5'h18, 32'h0, 32'h00000001, 4'd6},
    '{OP_W, 5'h18, 32'h00000001, 32'h0, 4'd8},
    '{OP_I, 5'h00, 32'h0, 32'h0, 4'd10},
    '{OP_W, 5'h0C, 32'hAAAAAAAE, 32'h0, 4'd4},        // R4 pin1 falling
    '{OP_P, 5'h00, 32'h00000003, 32'h0, 4'd4},
    '{OP_R, 5'h18, 32'h0, 32'h00000000, 4'd4},
    '{OP_P, 5'h00, 32'h00000001, 32'h0, 4'd4},
    '{OP_R, 5'h18, 32'h0, 32'h00000002, 4'd4},
    '{OP_W, 5'h18, 32'hFFFFFFFF, 32'h0, 4'd8},
    '{OP_W, 5'h10, 32'hAAAAAAA6, 32'h0, 4'd4},        // R4 pin17 high level
    '{OP_W, 5'h14, 32'h00020001, 32'h0, 4'd10},
    '{OP_W, 5'h15, 32'hFFFFFFFF, 32'h0, 4'd1},        // R1 misaligned write
    '{OP_R, 5'h14, 32'h0, 32'h00020001, 4'd1},
    '{OP_P, 5'h00, 32'h00020001, 32'h0, 4'd5},        // R5
    '{OP_R, 5'h18, 32'h0, 32'h00020000, 4'd5},
    '{OP_I, 5'h00, 32'h0, 32'h2, 4'd10},              // R10 irq_hi
    '{OP_W, 5'h18, 32'h00020000, 32'h0, 4'd9},        // R9 clear vs level
    '{OP_R, 5'h18, 32'h0, 32'h00020000, 4'd9},
    '{OP_P, 5'h00, 32'h00000001, 32'h0, 4'd5},
    '{OP_W, 5'h18, 32'h00020000, 32'h0, 4'd8},
    '{OP_R, 5'h18, 32'h0, 32'h00000000, 4'd5},
    '{OP_I, 5'h00, 32'h0, 32'h0, 4'd10},
    '{OP_W, 5'h1C, 32'h00100000, 32'h0, 4'd7},        // R7 pin20 both edges
    '{OP_R, 5'h1C, 32'h0, 32'h00100000, 4'd1},
    '{OP_P, 5'h00, 32'h00100001, 32'h0, 4'd7},
    '{OP_R, 5'h18, 32'h0, 32'h00100000, 4'd7},
    '{OP_W, 5'h18, 32'h00100000, 32'h0, 4'd8},
    '{OP_P, 5'h00, 32'h00000001, 32'h0, 4'd7},
    '{OP_R, 5'h18, 32'h0, 32'h00100000, 4'd7},
    '{OP_W, 5'h18, 32'hFFFFFFFF, 32'h0, 4'd8},
    '{OP_W, 5'h10, 32'h2AAAAAA6, 32'h0, 4'd4},        // R4 pin31 low level
    '{OP_R, 5'h18, 32'h0, 32'h80000000, 4'd4},
    '{OP_W, 5'h14, 32'hFFFFFFFF, 32'h0, 4'd10},
    '{OP_I, 5'h00, 32'h0, 32'h2, 4'd10},
    '{OP_W, 5'h18, 32'h80000000, 32'h0, 4'd5},
    '{OP_I, 5'h00, 32'h0, 32'h2, 4'd5},
    '{OP_R, 5'h10, 32'h0, 32'h2AAAAAA6, 4'd1},
    '{OP_R, 5'h0C, 32'h0, 32'hAAAAAAAE, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port uut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: values while reset is held
    check(11, bus_rdata, 32'h0);
    check(11, pad_oe, 32'h0);
    check(11, {30'h0, irq_hi, irq_lo}, 32'h0);
    rst = 1'b0;
    // R4: default code 00 is low level, pads are low
    do_rd(4, 5'h18, 32'hFFFFFFFF);

    for (int k = 0; k < NVEC; k++) begin
      case (VECS[k].op)
        OP_W: do_wr(VECS[k].addr, VECS[k].data);
        OP_R: do_rd(int'(VECS[k].req), VECS[k].addr, VECS[k].exp);
        OP_P: begin
          pad_in = VECS[k].data;
          repeat (4) @(posedge clk);
          @(negedge clk);
        end
        OP_I: begin
          @(posedge clk); @(negedge clk);
          check(int'(VECS[k].req), {30'h0, irq_hi, irq_lo}, VECS[k].exp);
        end
        default: check(int'(VECS[k].req), pad_out & pad_oe, VECS[k].exp);
      endcase
    end

    // R11: reset in mid-run returns all registers to zero
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(11, pad_oe, 32'h0);
    check(11, pad_out, 32'h0);
    check(11, {30'h0, irq_hi, irq_lo}, 32'h0);
    rst = 1'b0;
    do_rd(11, 5'h00, 32'h0);
    do_rd(11, 5'h04, 32'h0);
    do_rd(11, 5'h0C, 32'h0);
    do_rd(11, 5'h10, 32'h0);
    do_rd(11, 5'h14, 32'h0);
    do_rd(11, 5'h1C, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule